// File: doc/BRIEF.md
# Root Port Error Collector and Interrupt Generator

This block sits in a root port and gathers the error messages that arrive from the hierarchy below it. Each message carries a two-bit severity code and a 16-bit requester identifier. The block keeps a root error status word, which records which classes of error have been seen, whether more than one has arrived, and whether the first uncorrectable error was fatal. It also keeps a source word that holds the identifier of the first correctable sender and the identifier of the first uncorrectable sender.

Software owns a three-bit command word that enables interrupts for each class. Software clears status flags by writing ones to them. The interrupt condition is the OR, over the correctable, non-fatal and fatal classes, of the class enable AND its received flag. In level mode the block drives that condition on a registered level output. In message mode the block emits a one-cycle request when the condition rises from false to true, whether the rise comes from a new error or from a command write. The request carries the 5-bit vector held in the top field of the status word. The device loads that vector through a dedicated port, and software cannot change it.

Top module: `root_err_collector`

## Requirements
- R1: A correctable message (msg_sev=2'b01) captures msg_src into err_src[15:0] when root_status[0] is clear. If root_status[0] is already set, it sets root_status[1] and leaves err_src[15:0] unchanged. In both cases root_status[0] is 1 one cycle later.
- R2: An uncorrectable message (msg_sev=2'b10 non-fatal, 2'b11 fatal) captures msg_src into err_src[31:16] when root_status[2] is clear. Otherwise it sets root_status[3] and leaves err_src[31:16] unchanged. In both cases root_status[2] is 1 one cycle later.
- R3: A fatal message sets root_status[6], and also sets root_status[4] only if root_status[2] was clear before it. A non-fatal message sets root_status[5].
- R4: With msgint_en low, irq_level equals, one cycle after any change, the OR of (root_cmd[0]&root_status[0]), (root_cmd[1]&root_status[5]) and (root_cmd[2]&root_status[6]). Command writes take effect in this way.
- R5: With msgint_en high, msi_req pulses for exactly one cycle, in the same cycle the condition of R4 first becomes true. During that cycle msi_vec equals root_status[31:27].
- R6: No msi_req is produced by a message whose class is not enabled in root_cmd, or while the R4 condition was already true. irq_level stays low in message mode.
- R7: A write with sts_clr_we clears each of root_status[6:0] whose bit in sts_clr_data is 1. Bits written 0, the vector field and err_src are unchanged.
- R8: root_status[31:27] changes only on vec_load, which loads vec_in. root_cmd changes only on cmd_we.
- R9: After reset, root_status, err_src, root_cmd, irq_level and msi_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Error message present this cycle |
| msg_sev | input | 2 | Severity: 01 correctable, 10 non-fatal, 11 fatal, 00 ignored |
| msg_src | input | 16 | Requester identifier of the sender |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for the status flags |
| sts_clr_data | input | 32 | Clear mask; only bits 6:0 act |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 3 | New enables: 0 correctable, 1 non-fatal, 2 fatal |
| msgint_en | input | 1 | Select message-signalled interrupts (wins over level mode) |
| vec_load | input | 1 | Device strobe that loads the vector field |
| vec_in | input | 5 | Vector value to load |
| root_status | output | 32 | Root error status word |
| err_src | output | 32 | First sources: [15:0] correctable, [31:16] uncorrectable |
| root_cmd | output | 3 | Current command enables |
| irq_level | output | 1 | Level interrupt output |
| msi_req | output | 1 | One-cycle message interrupt request |
| msi_vec | output | 5 | Vector sent with msi_req |

## Verification
The properties assume a clear and a message in the same cycle act in a fixed order: the clear first, then the message. The bench keeps the two apart, so each check separates their effects. The properties also assume msgint_en is steady around a rise of the condition; the bench changes the mode only while the condition is false. Severity code 00 is treated as no message. The bench never sends it with msg_valid high, so every message belongs to exactly one class.

// File: rtl/root_err_pkg.sv
package root_err_pkg;
  typedef enum logic [1:0] {
    SEV_NONE     = 2'b00,
    SEV_COR      = 2'b01,
    SEV_NONFATAL = 2'b10,
    SEV_FATAL    = 2'b11
  } sev_t;

  localparam int ST_COR      = 0;
  localparam int ST_MCOR     = 1;
  localparam int ST_UNC      = 2;
  localparam int ST_MUNC     = 3;
  localparam int ST_FFATAL   = 4;
  localparam int ST_NF       = 5;
  localparam int ST_FATAL    = 6;
  localparam int FLAG_W      = 7;
  localparam int STATUS_W    = 32;
  localparam int CMD_W       = 3;
endpackage

// File: rtl/root_err_status.sv
module root_err_status
  import root_err_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  msg_valid,
  input  logic [1:0]            msg_sev,
  input  logic [SRC_W-1:0]      msg_src,
  input  logic                  sts_clr_we,
  input  logic [STATUS_W-1:0]   sts_clr_data,
  input  logic                  vec_load,
  input  logic [VEC_W-1:0]      vec_in,
  output logic [STATUS_W-1:0]   status_q,
  output logic [STATUS_W-1:0]   status_d,
  output logic [2*SRC_W-1:0]    src_q
);
  localparam int VEC_LO = STATUS_W - VEC_W;

  logic [2*SRC_W-1:0] src_d;
  logic is_cor, is_unc, is_fatal;

  always_comb begin
    is_cor   = msg_valid && (msg_sev == SEV_COR);
    is_unc   = msg_valid && msg_sev[1];
    is_fatal = msg_valid && (msg_sev == SEV_FATAL);
    status_d = status_q;
    src_d    = src_q;
    if (sts_clr_we)
      status_d[FLAG_W-1:0] = status_q[FLAG_W-1:0] & ~sts_clr_data[FLAG_W-1:0];
    if (vec_load)
      status_d[STATUS_W-1:VEC_LO] = vec_in;
    if (is_cor) begin
      if (status_d[ST_COR]) status_d[ST_MCOR] = 1'b1;
      else                  src_d[SRC_W-1:0] = msg_src;
      status_d[ST_COR] = 1'b1;
    end
    if (is_unc) begin
      if (status_d[ST_UNC]) status_d[ST_MUNC] = 1'b1;
      else begin
        src_d[2*SRC_W-1:SRC_W] = msg_src;
        if (is_fatal) status_d[ST_FFATAL] = 1'b1;
      end
      status_d[ST_UNC] = 1'b1;
      if (is_fatal) status_d[ST_FATAL] = 1'b1;
      else          status_d[ST_NF]    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      src_q    <= '0;
    end else begin
      status_q <= status_d;
      src_q    <= src_d;
    end
  end
endmodule

// File: rtl/root_err_irq.sv
module root_err_irq
  import root_err_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_we,
  input  logic [CMD_W-1:0]    cmd_wdata,
  input  logic                msgint_en,
  input  logic [STATUS_W-1:0] status_q,
  input  logic [STATUS_W-1:0] status_d,
  output logic [CMD_W-1:0]    cmd_q,
  output logic                irq_level,
  output logic                msi_req,
  output logic [VEC_W-1:0]    msi_vec
);
  localparam int VEC_LO = STATUS_W - VEC_W;

  logic [CMD_W-1:0] cmd_d;
  logic cond_now, cond_next;

  function automatic logic cond_of(input logic [CMD_W-1:0] c,
                                   input logic [STATUS_W-1:0] s);
    return (c[0] & s[ST_COR]) | (c[1] & s[ST_NF]) | (c[2] & s[ST_FATAL]);
  endfunction

  always_comb begin
    cmd_d     = cmd_we ? cmd_wdata : cmd_q;
    cond_now  = cond_of(cmd_q, status_q);
    cond_next = cond_of(cmd_d, status_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      irq_level <= 1'b0;
      msi_req   <= 1'b0;
      msi_vec   <= '0;
    end else begin
      cmd_q     <= cmd_d;
      irq_level <= !msgint_en && cond_next;
      msi_req   <= msgint_en && cond_next && !cond_now;
      msi_vec   <= status_d[STATUS_W-1:VEC_LO];
    end
  end
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import root_err_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_valid,
  input  logic [1:0]         msg_sev,
  input  logic [SRC_W-1:0]   msg_src,
  input  logic               sts_clr_we,
  input  logic [31:0]        sts_clr_data,
  input  logic               cmd_we,
  input  logic [2:0]         cmd_wdata,
  input  logic               msgint_en,
  input  logic               vec_load,
  input  logic [VEC_W-1:0]   vec_in,
  output logic [31:0]        root_status,
  output logic [2*SRC_W-1:0] err_src,
  output logic [2:0]         root_cmd,
  output logic               irq_level,
  output logic               msi_req,
  output logic [VEC_W-1:0]   msi_vec
);
  logic [STATUS_W-1:0] status_d;

  root_err_status #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u_status (
    .clk(clk), .rst(rst),
    .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
    .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
    .vec_load(vec_load), .vec_in(vec_in),
    .status_q(root_status), .status_d(status_d), .src_q(err_src)
  );

  root_err_irq #(.VEC_W(VEC_W)) u_irq (
    .clk(clk), .rst(rst),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .msgint_en(msgint_en),
    .status_q(root_status), .status_d(status_d),
    .cmd_q(root_cmd), .irq_level(irq_level),
    .msi_req(msi_req), .msi_vec(msi_vec)
  );
endmodule

// File: rtl/root_err_chk.sv
module root_err_chk #(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               msg_valid,
  input logic [1:0]         msg_sev,
  input logic [SRC_W-1:0]   msg_src,
  input logic               sts_clr_we,
  input logic [31:0]        sts_clr_data,
  input logic               cmd_we,
  input logic               vec_load,
  input logic [31:0]        root_status,
  input logic [2*SRC_W-1:0] err_src,
  input logic [2:0]         root_cmd,
  input logic               irq_level,
  input logic               msi_req,
  input logic [VEC_W-1:0]   msi_vec
);
  logic cor_kept;
  assign cor_kept = root_status[0] && !(sts_clr_we && sts_clr_data[0]);

  p_multi_cor_r1: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_sev == 2'b01 && cor_kept |=>
      root_status[1] && root_status[0] && err_src[SRC_W-1:0] == $past(err_src[SRC_W-1:0]));

  p_first_cor_r1: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_sev == 2'b01 && !root_status[0] |=>
      err_src[SRC_W-1:0] == $past(msg_src));

  p_first_unc_r2: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_sev[1] && !root_status[2] |=>
      err_src[2*SRC_W-1:SRC_W] == $past(msg_src) && root_status[2]);

  p_fatal_flag_r3: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_sev == 2'b11 |=> root_status[6]);

  p_msi_single_r5: assert property (@(posedge clk) disable iff (rst)
    msi_req |=> !msi_req);

  p_msi_vec_r5: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> msi_vec == root_status[31:32-VEC_W]);

  p_mode_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(msi_req && irq_level));

  p_vec_ro_r8: assert property (@(posedge clk) disable iff (rst)
    !vec_load |=> $stable(root_status[31:32-VEC_W]));

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd_we |=> $stable(root_cmd));
endmodule

bind root_err_collector root_err_chk #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_sev(msg_sev),
  .msg_src(msg_src), .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
  .cmd_we(cmd_we), .vec_load(vec_load), .root_status(root_status),
  .err_src(err_src), .root_cmd(root_cmd), .irq_level(irq_level),
  .msi_req(msi_req), .msi_vec(msi_vec)
);

// File: tb/root_err_collector_tb.sv
module root_err_collector_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_sev = 2'b00;
  logic [15:0] msg_src = '0;
  logic        sts_clr_we = 1'b0;
  logic [31:0] sts_clr_data = '0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_wdata = '0;
  logic        msgint_en = 1'b0;
  logic        vec_load = 1'b0;
  logic [4:0]  vec_in = '0;
  logic [31:0] root_status, err_src;
  logic [2:0]  root_cmd;
  logic        irq_level, msi_req;
  logic [4:0]  msi_vec;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  root_err_collector u_dut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src), .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .msgint_en(msgint_en),
    .vec_load(vec_load), .vec_in(vec_in), .root_status(root_status),
    .err_src(err_src), .root_cmd(root_cmd), .irq_level(irq_level),
    .msi_req(msi_req), .msi_vec(msi_vec)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // each task drives after a negedge and returns just after the next negedge
  task automatic send(input logic [1:0] sev, input logic [15:0] src);
    @(negedge clk); msg_valid = 1'b1; msg_sev = sev; msg_src = src;
    @(negedge clk); msg_valid = 1'b0; msg_sev = 2'b00;
  endtask

  task automatic clr(input logic [31:0] m);
    @(negedge clk); sts_clr_we = 1'b1; sts_clr_data = m;
    @(negedge clk); sts_clr_we = 1'b0; sts_clr_data = '0;
  endtask

  task automatic wcmd(input logic [2:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 status", root_status, 32'h0);
    check("R9 src", err_src, 32'h0);
    check("R9 cmd", {29'd0, root_cmd}, 32'h0);
    check("R9 irq", {30'd0, irq_level, msi_req}, 32'h0);
  endtask

  task automatic t_correctable();
    send(2'b01, 16'hA001);
    check("R1 first cor status", root_status, 32'h0000_0001);
    check("R1 first cor src", err_src, 32'h0000_A001);
    send(2'b01, 16'hA002);
    check("R1 multi cor status", root_status, 32'h0000_0003);
    check("R1 multi cor src kept", err_src, 32'h0000_A001);
    check("R6 no irq when disabled", {30'd0, irq_level, msi_req}, 32'h0);
  endtask

  task automatic t_uncorrectable();
    send(2'b10, 16'hB010);
    check("R2 R3 nonfatal status", root_status, 32'h0000_0027);
    check("R2 first unc src", err_src, 32'hB010_A001);
    send(2'b11, 16'hB020);
    check("R3 fatal not first", root_status, 32'h0000_006F);
    check("R2 unc src kept", err_src, 32'hB010_A001);
  endtask

  task automatic t_clear();
    clr(32'h0000_0000);
    check("R7 zero write no effect", root_status, 32'h0000_006F);
    clr(32'hFFFF_FFFF);
    check("R7 clear all flags", root_status, 32'h0000_0000);
    check("R7 src untouched", err_src, 32'hB010_A001);
    send(2'b11, 16'hC0DE);
    check("R3 first fatal", root_status, 32'h0000_0054);
    check("R2 new unc src", err_src, 32'hC0DE_A001);
    clr(32'h0000_0010);
    check("R7 partial clear", root_status, 32'h0000_0044);
  endtask

  task automatic t_level();
    wcmd(3'b100);
    check("R4 level on cmd write", {31'd0, irq_level}, 32'h1);
    check("R8 cmd readback", {29'd0, root_cmd}, 32'h4);
    wcmd(3'b011);
    check("R4 level drops", {31'd0, irq_level}, 32'h0);
    send(2'b01, 16'h0001);
    check("R4 level on cor msg", {31'd0, irq_level}, 32'h1);
    clr(32'h0000_007F);
    check("R4 level after clear", {31'd0, irq_level}, 32'h0);
  endtask

  task automatic t_message();
    @(negedge clk); vec_load = 1'b1; vec_in = 5'd19; msgint_en = 1'b1;
    @(negedge clk); vec_load = 1'b0;
    check("R8 vector loaded", {27'd0, root_status[31:27]}, 32'd19);
    clr(32'hFFFF_FFFF);
    check("R7 R8 vector survives clear", {27'd0, root_status[31:27]}, 32'd19);
    send(2'b11, 16'h0002);
    check("R6 fatal not enabled no msi", {31'd0, msi_req}, 32'h0);
    send(2'b10, 16'h0003);
    check("R5 msi on rise", {26'd0, msi_req, msi_vec}, {26'd0, 1'b1, 5'd19});
    check("R6 level low in msg mode", {31'd0, irq_level}, 32'h0);
    @(negedge clk);
    check("R5 single cycle", {31'd0, msi_req}, 32'h0);
    send(2'b01, 16'h0004);
    check("R6 already true no msi", {31'd0, msi_req}, 32'h0);
    clr(32'h0000_007F);
    send(2'b11, 16'h0005);
    check("R6 disabled class no msi", {31'd0, msi_req}, 32'h0);
    wcmd(3'b111);
    check("R5 msi on cmd write", {26'd0, msi_req, msi_vec}, {26'd0, 1'b1, 5'd19});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_correctable();
    t_uncorrectable();
    t_clear();
    t_level();
    t_message();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule